// File: doc/BRIEF.md
# Sync-Armed Receive FIFO Fill Controller

This block decides which received bytes are written into a downstream byte FIFO. A deserializer delivers bytes with a one-cycle valid strobe, and a correlator delivers a one-cycle pulse when a sync word has been found. A configuration bit chooses between two ways of opening the write path. In automatic capture, a sync pulse opens it. In manual capture, software opens and closes it with a register write. A status bit that software can read shows whether capture is currently open.

The gating applies only when the receive path is configured for buffered operation. In the other path modes, every valid byte goes straight to the FIFO whenever the FIFO has room. The block has a small two-address register port, the byte stream input, the sync pulse input, and a FIFO write interface that takes the FIFO's full and empty flags as inputs.

Top module: `rxf_fill_ctrl`

## Requirements
- R1: After reset, the capture method is automatic (config bit 0 = 0), the path mode is buffered (config bits 2:1 = 2'b01), capture is closed and the overflow flag is clear. A read of address 0 returns 0x02. A read of address 1 returns {5'b0, fifo_empty, overflow, capture_open} in bits 2, 1 and 0.
- R2: In automatic buffered mode, a sync pulse while capture is closed opens capture at the next clock edge. From that cycle on, status bit 0 of address 1 reads 1, and each valid byte is passed to the FIFO in the same cycle it arrives.
- R3: In buffered mode, a valid byte that arrives while capture is closed is not written: fifo_wr_en stays 0.
- R4: A sync pulse that arrives while capture is open has no effect: capture stays open and the byte in that cycle is written normally.
- R5: In automatic mode, any write to address 1 closes capture at the next edge. The next sync pulse opens it again.
- R6: In manual buffered mode, a write to address 1 sets capture open to that write's bit 0 (1 starts, 0 stops) at the next edge. Sync pulses do not open capture in this mode.
- R7: A valid byte that arrives while writing is enabled but fifo_full is 1 is dropped, and the overflow flag (address 1, bit 1) is set. In automatic mode that drop also closes capture. In manual mode capture stays open.
- R8: The overflow flag stays set until a write to address 1 with bit 1 = 1 clears it.
- R9: When the path mode is not 2'b01, every valid byte is written while fifo_full is 0, independent of capture state, and status bit 0 reads 0.
- R10: fifo_wr_en is never 1 while fifo_full is 1.
- R11: A write to address 0 closes capture at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 = config, 1 = control/status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| sync_hit | input | 1 | Sync-word detected pulse |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_wr_en | output | 1 | FIFO write enable |
| fifo_wr_data | output | 8 | FIFO write data |

## Verification
On every cycle, the assertions check these properties:
- no write reaches a full FIFO;
- a closed capture gate blocks writes in buffered mode;
- a sync pulse during open capture leaves capture open;
- overflow is sticky;
- a control write closes capture in automatic mode and opens it in manual mode.

Only the bench scenarios can show the orderings across several steps:
- sync re-arming after a clear;
- manual mode ignoring sync;
- a full-FIFO drop closing capture only in automatic mode;
- the bypass behaviour of non-buffered path modes;
- the exact read-back encodings.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        PATH_STREAM = 2'b00,
        PATH_BUFFER = 2'b01,
        PATH_PKT_A  = 2'b10,
        PATH_PKT_B  = 2'b11
    } path_mode_e;

    typedef struct packed {
        path_mode_e path;
        logic       manual;
    } fill_cfg_t;

    localparam fill_cfg_t CFG_RESET = '{path: PATH_BUFFER, manual: 1'b0};

    typedef struct packed {
        logic cfg_wr;
        logic ctl_wr;
        logic ctl_start;
        logic ovf_clr;
    } reg_evt_t;

    function automatic logic is_buffered(input path_mode_e p);
        return p == PATH_BUFFER;
    endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             st_open,
    input  logic             st_ovf,
    input  logic             st_empty,
    output fill_cfg_t        cfg,
    output reg_evt_t         evt
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RESET;
        else if (reg_wr && !reg_addr)
            cfg <= '{path: path_mode_e'(reg_wdata[2:1]), manual: reg_wdata[0]};
    end

    always_comb begin
        evt.cfg_wr    = reg_wr && !reg_addr;
        evt.ctl_wr    = reg_wr && reg_addr;
        evt.ctl_start = reg_wdata[0];
        evt.ovf_clr   = reg_wdata[1];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr)
            reg_rdata[2:0] = {st_empty, st_ovf, st_open};
        else
            reg_rdata[2:0] = {cfg.path, cfg.manual};
    end
endmodule

// File: rtl/rxf_fill_fsm.sv
module rxf_fill_fsm
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fill_cfg_t cfg,
    input  reg_evt_t  evt,
    input  logic      sync_hit,
    input  logic      byte_valid,
    input  logic      fifo_full,
    output logic      cap_open,
    output logic      ovf
);
    logic buffered;
    logic wr_allowed;
    logic drop;

    always_comb begin
        buffered   = is_buffered(cfg.path);
        wr_allowed = buffered ? cap_open : 1'b1;
        drop       = wr_allowed && byte_valid && fifo_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_open <= 1'b0;
        end else if (!buffered || evt.cfg_wr) begin
            cap_open <= 1'b0;
        end else if (cfg.manual) begin
            if (evt.ctl_wr)
                cap_open <= evt.ctl_start;
        end else begin
            if (evt.ctl_wr)
                cap_open <= 1'b0;
            else if (!cap_open && sync_hit)
                cap_open <= 1'b1;
            else if (drop)
                cap_open <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else if (evt.ctl_wr && evt.ovf_clr)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
    end

    // R4
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_open && sync_hit && !evt.cfg_wr && !evt.ctl_wr && !(byte_valid && fifo_full))
        |=> cap_open);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(evt.ctl_wr && evt.ovf_clr)) |=> ovf);

    // R5
    auto_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.ctl_wr && !cfg.manual) |=> !cap_open);

    // R6
    manual_start_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.ctl_wr && cfg.manual && buffered && evt.ctl_start) |=> cap_open);
endmodule

// File: rtl/rxf_wr_gate.sv
module rxf_wr_gate
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  fill_cfg_t         cfg,
    input  logic              cap_open,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              fifo_full,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data
);
    logic pass;

    always_comb begin
        pass         = is_buffered(cfg.path) ? cap_open : 1'b1;
        fifo_wr_en   = pass && byte_valid && !fifo_full;
        fifo_wr_data = byte_data;
    end

    // R10
    no_full_write_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> !fifo_full);

    // R3
    closed_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (is_buffered(cfg.path) && !cap_open) |-> !fifo_wr_en);
endmodule

// File: rtl/rxf_fill_ctrl.sv
module rxf_fill_ctrl
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              sync_hit,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data
);
    fill_cfg_t cfg;
    reg_evt_t  evt;
    logic      cap_open;
    logic      ovf;

    rxf_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_open(cap_open), .st_ovf(ovf), .st_empty(fifo_empty),
        .cfg(cfg), .evt(evt)
    );

    rxf_fill_fsm u_fsm (
        .clk(clk), .rst(rst), .cfg(cfg), .evt(evt), .sync_hit(sync_hit),
        .byte_valid(byte_valid), .fifo_full(fifo_full),
        .cap_open(cap_open), .ovf(ovf)
    );

    rxf_wr_gate #(.DATA_W(DATA_W)) u_gate (
        .clk(clk), .rst(rst), .cfg(cfg), .cap_open(cap_open),
        .byte_valid(byte_valid), .byte_data(byte_data), .fifo_full(fifo_full),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data)
    );
endmodule

// File: tb/rxf_fill_ctrl_tb.sv
module rxf_fill_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       sync_hit = 1'b0;
    logic       fifo_full = 1'b0;
    logic       fifo_empty = 1'b1;
    logic       fifo_wr_en;
    logic [7:0] fifo_wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxf_fill_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_valid(byte_valid),
        .byte_data(byte_data), .sync_hit(sync_hit), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_chk(input string req, input logic a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic byte_chk(input string req, input logic [7:0] d, input logic exp_wr);
        byte_valid = 1'b1; byte_data = d;
        #1;
        check(req, {7'b0, fifo_wr_en}, {7'b0, exp_wr});
        if (exp_wr) check(req, fifo_wr_data, d);
    endtask

    task automatic t_reset();
        read_chk("R1", 1'b0, 8'h02);
        read_chk("R1", 1'b1, 8'h04);
        check("R1", {7'b0, fifo_wr_en}, 8'h00);
    endtask

    task automatic t_idle_drop();
        byte_chk("R3", 8'h11, 1'b0);
        tick(); byte_valid = 1'b0;
    endtask

    task automatic t_auto_start();
        sync_hit = 1'b1; tick(); sync_hit = 1'b0;
        read_chk("R2", 1'b1, 8'h05);
        fifo_empty = 1'b0;
        byte_chk("R2", 8'hA5, 1'b1);
        tick(); byte_valid = 1'b0;
    endtask

    task automatic t_sync_active();
        sync_hit = 1'b1;
        byte_chk("R4", 8'h3C, 1'b1);
        tick(); sync_hit = 1'b0; byte_valid = 1'b0;
        read_chk("R4", 1'b1, 8'h01);
    endtask

    task automatic t_auto_clear();
        reg_write(1'b1, 8'h00);
        read_chk("R5", 1'b1, 8'h00);
        byte_chk("R5", 8'h22, 1'b0);
        tick(); byte_valid = 1'b0;
        sync_hit = 1'b1; tick(); sync_hit = 1'b0;
        read_chk("R5", 1'b1, 8'h01);
    endtask

    task automatic t_full_auto();
        fifo_full = 1'b1;
        byte_chk("R10", 8'h44, 1'b0);
        tick(); byte_valid = 1'b0;
        read_chk("R7", 1'b1, 8'h02);
        tick(); tick();
        read_chk("R8", 1'b1, 8'h02);
        fifo_full = 1'b0;
        reg_write(1'b1, 8'h02);
        read_chk("R8", 1'b1, 8'h00);
    endtask

    task automatic t_cfg_clear();
        sync_hit = 1'b1; tick(); sync_hit = 1'b0;
        read_chk("R11", 1'b1, 8'h01);
        reg_write(1'b0, 8'h03);
        read_chk("R11", 1'b1, 8'h00);
        read_chk("R11", 1'b0, 8'h03);
    endtask

    task automatic t_manual();
        sync_hit = 1'b1; tick(); sync_hit = 1'b0;
        read_chk("R6", 1'b1, 8'h00);
        reg_write(1'b1, 8'h01);
        read_chk("R6", 1'b1, 8'h01);
        byte_chk("R6", 8'h5A, 1'b1);
        tick(); byte_valid = 1'b0;
        fifo_full = 1'b1;
        byte_chk("R7", 8'h66, 1'b0);
        tick(); byte_valid = 1'b0; fifo_full = 1'b0;
        read_chk("R7", 1'b1, 8'h03);
        reg_write(1'b1, 8'h02);
        read_chk("R6", 1'b1, 8'h00);
        byte_chk("R6", 8'h77, 1'b0);
        tick(); byte_valid = 1'b0;
    endtask

    task automatic t_bypass();
        reg_write(1'b0, 8'h00);
        read_chk("R9", 1'b1, 8'h00);
        byte_chk("R9", 8'h88, 1'b1);
        tick();
        fifo_full = 1'b1;
        byte_chk("R9", 8'h99, 1'b0);
        tick(); byte_valid = 1'b0; fifo_full = 1'b0;
        reg_write(1'b0, 8'h04);
        byte_chk("R9", 8'hAA, 1'b1);
        tick(); byte_valid = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_idle_drop();
        t_auto_start();
        t_sync_active();
        t_auto_clear();
        t_full_auto();
        t_cfg_clear();
        t_manual();
        t_bypass();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule